// File: doc/BRIEF.md
# Dual-Side Doorbell Interrupt Register

This block is a mailbox-style doorbell unit placed between an external bus master and the local processor's register bus. The external master raises notifications by writing ones into a flag word. Each write-one sets the flags it names and never clears any. The local processor reads the same word, handles each pending notification and then acknowledges it by writing a one to that flag. The top flag is special. Raising it asks the local processor to take a machine check. The lower flags together drive an ordinary doorbell interrupt.

Beside the flag word, a small status word sums up what is pending. It also carries one message-event bit. A one-cycle pulse on an input sets that bit, and a write-one from the local side clears it. Both ports are plain register-write ports with no handshake. A write completes in the cycle in which its enable is high. Both read ports are combinational. The two interrupt outputs are level signals. Each stays high until the local side clears the flags behind it.

Top module: `dbell_mailbox`

## Requirements
- R1: While reset is asserted, and right after it, the flag word reads 0x00000000 from both sides, the status word reads 0 and both interrupt outputs are low.
- R2: An external write sets every flag whose data bit is 1, and the change is visible after the next rising clock edge.
- R3: A local write to offset 0x080 clears every flag whose data bit is 1.
- R4: A data bit of 0 leaves its flag unchanged, whether the write comes from the external side or the local side.
- R5: When an external set and a local clear target the same flag in the same cycle, the flag ends up set.
- R6: `db_irq` is high exactly when at least one of flags 30..0 is set.
- R7: `mc_irq` is high exactly when flag 31 is set.
- R8: `ext_rd_data` always shows the flag word. A local read at offset 0x080 returns the same value.
- R9: A local read at offset 0x068 returns the status word. Bit 1 is 1 while any of flags 30..0 is set, bit 2 equals flag 31, and all other bits except bit 0 read 0. Writes to bits 1 and 2 have no effect.
- R10: Status bit 0 is set by a pulse on `msg_evt`. A local write to 0x068 with data bit 0 equal to 1 clears it, and a 0 in that bit leaves it unchanged. If a pulse and a clear arrive in the same cycle, the bit ends up set.
- R11: A local read of any offset other than 0x080 or 0x068 returns 0. A local write to such an offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_wr_en | input | 1 | External write strobe |
| ext_wr_data | input | 32 | External set mask |
| ext_rd_data | output | 32 | Flag word as seen by the external side |
| loc_wr_en | input | 1 | Local write strobe |
| loc_addr | input | 8 | Local byte offset, used for both reads and writes |
| loc_wr_data | input | 32 | Local write data (clear mask) |
| loc_rd_data | output | 32 | Local read data for `loc_addr` |
| msg_evt | input | 1 | Message-event pulse |
| db_irq | output | 1 | Doorbell interrupt level |
| mc_irq | output | 1 | Machine-check interrupt level |

## Verification
The bench goes after three kinds of corner case.

Set/clear collisions on the same flag are the first. A design that gave the clear priority would drop a doorbell, and the bench would read a zero where a one belongs. The same collision on the message bit is tested as well.

The boundary between flag 30 and flag 31 is the second. A design that folded bit 31 into the doorbell OR would raise `db_irq` for a machine check alone. A design that left bit 30 out would miss a doorbell.

The address decode is the third. A full sweep of the offset range, with reads and all-ones writes at every unmapped offset, would expose a decoder that aliases, for example one that ignores the high address bits, by returning data or clearing flags.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  // bit positions inside the status word
  localparam int STS_MSG = 0;
  localparam int STS_DB  = 1;
  localparam int STS_MC  = 2;
endpackage

// File: rtl/dbell_flag_bank.sv
module dbell_flag_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags
);
  // one sticky cell per flag; a set outranks a clear in the same cycle
  for (genvar i = 0; i < W; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags[i] <= 1'b0;
      else if (set_mask[i]) flags[i] <= 1'b1;
      else if (clr_mask[i]) flags[i] <= 1'b0;
    end
  end

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((flags & $past(set_mask)) == $past(set_mask)));

  p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_mask)) |=> ((flags & $past(clr_mask & ~set_mask)) == '0));

  p_untouched_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flags ^ $past(flags)) & ~$past(set_mask | clr_mask)) == '0));
endmodule

// File: rtl/dbell_status.sv
module dbell_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msg_evt,
  input  logic         msg_clr,
  input  logic         db_pend,
  input  logic         mc_pend,
  output logic [W-1:0] sts_word
);
  import dbell_pkg::*;

  logic msg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       msg_q <= 1'b0;
    else if (msg_evt) msg_q <= 1'b1;
    else if (msg_clr) msg_q <= 1'b0;
  end

  always_comb begin
    sts_word          = '0;
    sts_word[STS_MSG] = msg_q;
    sts_word[STS_DB]  = db_pend;
    sts_word[STS_MC]  = mc_pend;
  end

  p_msg_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_evt |=> msg_q);

  p_msg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_clr && !msg_evt) |=> !msg_q);
endmodule

// File: rtl/dbell_rd_mux.sv
module dbell_rd_mux #(
  parameter int             W      = 32,
  parameter int             ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_DB  = 8'h80,
  parameter logic [ADDR_W-1:0] OFS_STS = 8'h68
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      flags,
  input  logic [W-1:0]      sts_word,
  output logic [W-1:0]      rd_data
);
  always_comb begin
    unique case (addr)
      OFS_DB:  rd_data = flags;
      OFS_STS: rd_data = sts_word;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox #(
  parameter int                W       = 32,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] OFS_DB  = 8'h80,
  parameter logic [ADDR_W-1:0] OFS_STS = 8'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_wr_en,
  input  logic [W-1:0]      ext_wr_data,
  output logic [W-1:0]      ext_rd_data,
  input  logic              loc_wr_en,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [W-1:0]      loc_wr_data,
  output logic [W-1:0]      loc_rd_data,
  input  logic              msg_evt,
  output logic              db_irq,
  output logic              mc_irq
);
  localparam int MC_BIT = W - 1;

  logic [W-1:0] flags, sts_word, set_mask, clr_mask;
  logic         hit_db, hit_sts;

  assign hit_db   = loc_wr_en && (loc_addr == OFS_DB);
  assign hit_sts  = loc_wr_en && (loc_addr == OFS_STS);
  assign set_mask = ext_wr_en ? ext_wr_data : '0;
  assign clr_mask = hit_db ? loc_wr_data : '0;

  dbell_flag_bank #(.W(W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_mask(set_mask), .clr_mask(clr_mask), .flags(flags)
  );

  assign db_irq = |flags[MC_BIT-1:0];
  assign mc_irq = flags[MC_BIT];

  dbell_status #(.W(W)) u_sts (
    .clk(clk), .rst_n(rst_n),
    .msg_evt(msg_evt), .msg_clr(hit_sts && loc_wr_data[dbell_pkg::STS_MSG]),
    .db_pend(db_irq), .mc_pend(mc_irq), .sts_word(sts_word)
  );

  dbell_rd_mux #(.W(W), .ADDR_W(ADDR_W), .OFS_DB(OFS_DB), .OFS_STS(OFS_STS)) u_rd (
    .addr(loc_addr), .flags(flags), .sts_word(sts_word), .rd_data(loc_rd_data)
  );

  assign ext_rd_data = flags;

  p_db_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(db_irq) |-> $past(ext_wr_en && (|ext_wr_data[MC_BIT-1:0])));

  p_mc_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_irq) |-> $past(ext_wr_en && ext_wr_data[MC_BIT]));

  p_mc_fall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mc_irq) |-> $past(hit_db && loc_wr_data[MC_BIT]));
endmodule

// File: tb/dbell_mailbox_tb.sv
module dbell_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_wr_en = 1'b0, loc_wr_en = 1'b0, msg_evt = 1'b0;
  logic [31:0] ext_wr_data = '0, loc_wr_data = '0;
  logic [7:0]  loc_addr = '0;
  logic [31:0] ext_rd_data, loc_rd_data;
  logic        db_irq, mc_irq;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_flags = '0;
  logic        m_msg = 1'b0;
  logic [31:0] lf = 32'h1234_5678;

  always #5 clk = ~clk;

  dbell_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .ext_wr_en(ext_wr_en), .ext_wr_data(ext_wr_data), .ext_rd_data(ext_rd_data),
    .loc_wr_en(loc_wr_en), .loc_addr(loc_addr), .loc_wr_data(loc_wr_data),
    .loc_rd_data(loc_rd_data), .msg_evt(msg_evt), .db_irq(db_irq), .mc_irq(mc_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(logic [31:0] v);
    logic [31:0] x = v;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic [31:0] exp_sts();
    return {29'd0, m_flags[31], |m_flags[30:0], m_msg};
  endfunction

  // one write cycle, model updated by the requirements
  task automatic cyc(logic ew, logic [31:0] ed, logic lw, logic [7:0] la,
                     logic [31:0] ld, logic me);
    ext_wr_en = ew; ext_wr_data = ed; loc_wr_en = lw; loc_addr = la;
    loc_wr_data = ld; msg_evt = me;
    @(posedge clk); #1;
    ext_wr_en = 0; loc_wr_en = 0; msg_evt = 0;
    if (lw && la == 8'h80) m_flags = m_flags & ~ld;   // R3
    if (ew) m_flags = m_flags | ed;                   // R2, R5: set wins
    if (lw && la == 8'h68 && ld[0]) m_msg = 1'b0;     // R10
    if (me) m_msg = 1'b1;                             // R10 set wins
  endtask

  task automatic check_all(string tag);
    chk({tag, " R8 ext view"}, ext_rd_data, m_flags);
    loc_addr = 8'h80; #1;
    chk({tag, " R8 local view"}, loc_rd_data, m_flags);
    loc_addr = 8'h68; #1;
    chk({tag, " R9 status"}, loc_rd_data, exp_sts());
    chk({tag, " R6 db_irq"}, {31'd0, db_irq}, {31'd0, |m_flags[30:0]});
    chk({tag, " R7 mc_irq"}, {31'd0, mc_irq}, {31'd0, m_flags[31]});
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 after reset");

    // walk each flag: set, zero writes, clear
    for (int i = 0; i < 32; i++) begin
      cyc(1, 32'd1 << i, 0, 8'h00, 0, 0);
      check_all("R2 walk set");
      cyc(1, 32'd0, 1, 8'h80, 32'd0, 0);
      check_all("R4 zero writes");
      cyc(0, 0, 1, 8'h80, 32'd1 << i, 0);
      check_all("R3 walk clear");
    end

    // collisions on every flag
    for (int i = 0; i < 32; i++) begin
      cyc(1, 32'd1 << i, 1, 8'h80, 32'hFFFF_FFFF, 0);
      check_all("R5 collision");
    end
    cyc(0, 0, 1, 8'h80, 32'hFFFF_FFFF, 0);
    check_all("R3 full clear");

    // status bits 1/2 read-only, message bit behaviour
    cyc(1, 32'h8000_0001, 0, 0, 0, 1);
    cyc(0, 0, 1, 8'h68, 32'h0000_0006, 0);
    check_all("R9 ro bits");
    cyc(0, 0, 1, 8'h68, 32'h0000_0001, 1);
    check_all("R10 pulse beats clear");
    cyc(0, 0, 1, 8'h68, 32'h0000_0001, 0);
    check_all("R10 clear");

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      lf = nxt(lf); a = lf;
      lf = nxt(lf); b = lf;
      cyc(a[0], b & nxt(a), a[1], a[2] ? 8'h80 : (a[3] ? 8'h68 : a[15:8]),
          nxt(b), a[4] & a[5]);
      check_all("R2 R3 mixed");
    end

    // address sweep: unmapped reads zero, unmapped writes inert
    cyc(1, 32'hA5A5_5A5A, 0, 0, 0, 1);
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h80 && a != 8'h68) begin
        cyc(0, 0, 1, a[7:0], 32'hFFFF_FFFF, 0);
        loc_addr = a[7:0]; #1;
        chk("R11 unmapped read", loc_rd_data, 32'd0);
        chk("R11 unmapped write inert", ext_rd_data, m_flags);
      end
    end
    check_all("R11 end state");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule